// File: doc/BRIEF.md
# Four-Multiplier Sum-of-Products Unit

This block is a pipelined multiply-add slice. It has up to four multipliers, and each one takes an A operand and a B operand. The products are grouped into two pairs. Within a pair, the second product is either added to the first or subtracted from it. The two pair results are then summed, together with a cascade input that carries the result of an upstream slice. The total either overwrites a running accumulator or is added into it. The accumulator register drives the result bus.

Two run-time controls set how operands are read: one makes all A operands signed or unsigned, and the other does the same for all B operands. The A operands can also be shifted in along a scan chain instead of loaded in parallel. The A value held by the last multiplier leaves on a scan output, so several slices can be daisy-chained. The pipeline has three register stages: operands, products, then the accumulated result. Every control travels through the pipeline alongside the data it applies to.

Top module: `sop4_unit`

## Requirements
- R1: When `sgn_a_i` is 1, every A operand is read as two's complement. When it is 0, every A operand is read as unsigned.
- R2: `sgn_b_i` applies the same rule to every B operand: 1 means signed, 0 means unsigned.
- R3: With `add_lo_i` = 1 the sum of products includes p0 + p1. With 0 it includes p0 - p1.
- R4: With `add_hi_i` = 1 the sum of products includes p2 + p3. With 0 it includes p3 subtracted from p2.
- R5: With `load_i` = 1 the accumulator takes the new total and drops its old value. With 0 the new total is added to the stored value, wrapping modulo 2^RES_W.
- R6: `chain_i` is read as a RES_W-bit two's-complement value and added into the total.
- R7: With `scan_sel_i` = 1, the parallel A inputs are ignored. Multiplier 0 takes `scan_in_i`, and multiplier k takes the A value that multiplier k-1 held. `scan_out_o` shows the A value held by the last multiplier, one clock after capture.
- R8: A set of operands and controls presented before clock edge n appears on `result_o` after edge n+2, which is the third capturing edge. Operand k is bits [8k+7:8k] of `a_i` and `b_i` at default widths. The result width holds four full unsigned products without loss.
- R9: While `en_i` is 0 and `clr_i` is 0, every register holds its value, so `result_o` and `scan_out_o` stay stable. Operation resumes unchanged when `en_i` returns to 1.
- R10: `clr_i` high at a clock edge zeroes every register, including the accumulator and the scan chain, whatever the value of `en_i`.
- R11: `rst_ni` low zeroes every register at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable for all stages |
| clr_i | input | 1 | Synchronous clear of all stages |
| sgn_a_i | input | 1 | A operands signed (1) or unsigned (0) |
| sgn_b_i | input | 1 | B operands signed (1) or unsigned (0) |
| add_lo_i | input | 1 | Pair 0/1: add (1) or subtract (0) |
| add_hi_i | input | 1 | Pair 2/3: add (1) or subtract (0) |
| load_i | input | 1 | Accumulator load (1) or accumulate (0) |
| scan_sel_i | input | 1 | A operands from the scan chain (1) or from `a_i` (0) |
| a_i | input | NUM_MUL*A_W | Parallel A operands, operand k in slice k |
| b_i | input | NUM_MUL*B_W | B operands, operand k in slice k |
| scan_in_i | input | A_W | Scan chain entry for multiplier 0 |
| chain_i | input | RES_W | Cascade input from an upstream slice |
| result_o | output | RES_W | Accumulator value |
| scan_out_o | output | A_W | A operand held by the last multiplier |

## Verification
A bad sign-extension or pair-sign flag shows up as a wrong `result_o` exactly three clocks after the offending operands. A corrupted accumulator is different: the error never goes away. It carries into every later result until a load or a clear, so each accumulate run is closed with a load that must restore an exact value. A scan-chain fault appears on `scan_out_o` one clock after capture. Because each A operand takes a position-dependent number of shifts to reach the output, a wrong shift order is visible within four clocks. Enable and clear faults are visible on the very next edge, as a moving or non-zero output.

// File: rtl/sop4_pkg.sv
package sop4_pkg;

  typedef struct packed {
    logic sgn_a;
    logic sgn_b;
    logic add_lo;
    logic add_hi;
    logic load;
  } sop_ctrl_t;

endpackage

// File: rtl/sop4_in_stage.sv
module sop4_in_stage
  import sop4_pkg::*;
#(
  parameter int NUM_MUL = 4,
  parameter int A_W     = 8,
  parameter int B_W     = 8,
  parameter int RES_W   = 48
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            en_i,
  input  logic                            clr_i,
  input  logic [NUM_MUL*A_W-1:0]          a_i,
  input  logic [NUM_MUL*B_W-1:0]          b_i,
  input  logic [A_W-1:0]                  scan_in_i,
  input  logic                            scan_sel_i,
  input  sop_ctrl_t                       ctrl_i,
  input  logic [RES_W-1:0]                chain_i,
  output logic [NUM_MUL-1:0][A_W-1:0]     a_q_o,
  output logic [NUM_MUL-1:0][B_W-1:0]     b_q_o,
  output sop_ctrl_t                       ctrl_q_o,
  output logic [RES_W-1:0]                chain_q_o
);

  logic [NUM_MUL-1:0][A_W-1:0] a_nxt;

  // scan chain: slot 0 from scan_in, slot k from slot k-1
  for (genvar k = 0; k < NUM_MUL; k++) begin : g_a_src
    if (k == 0) begin : g_head
      assign a_nxt[k] = scan_sel_i ? scan_in_i : a_i[k*A_W +: A_W];
    end else begin : g_body
      assign a_nxt[k] = scan_sel_i ? a_q_o[k-1] : a_i[k*A_W +: A_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q_o     <= '0;
      b_q_o     <= '0;
      ctrl_q_o  <= '0;
      chain_q_o <= '0;
    end else if (clr_i) begin
      a_q_o     <= '0;
      b_q_o     <= '0;
      ctrl_q_o  <= '0;
      chain_q_o <= '0;
    end else if (en_i) begin
      a_q_o     <= a_nxt;
      b_q_o     <= b_i;
      ctrl_q_o  <= ctrl_i;
      chain_q_o <= chain_i;
    end
  end

endmodule

// File: rtl/sop4_mul.sv
module sop4_mul #(
  parameter int A_W = 8,
  parameter int B_W = 8,
  parameter int P_W = A_W + B_W + 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           clr_i,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  input  logic           sgn_a_i,
  input  logic           sgn_b_i,
  output logic [P_W-1:0] prod_o
);

  logic signed [A_W:0]   ext_a;
  logic signed [B_W:0]   ext_b;
  logic signed [P_W-1:0] prod_d;

  // one extra bit turns either encoding into a signed value
  assign ext_a  = {sgn_a_i & a_i[A_W-1], a_i};
  assign ext_b  = {sgn_b_i & b_i[B_W-1], b_i};
  assign prod_d = P_W'(ext_a) * P_W'(ext_b);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prod_o <= '0;
    else if (clr_i)  prod_o <= '0;
    else if (en_i)   prod_o <= prod_d;
  end

endmodule

// File: rtl/sop4_adder.sv
module sop4_adder #(
  parameter int NUM_MUL = 4,
  parameter int P_W     = 18,
  parameter int RES_W   = 48
) (
  input  logic [NUM_MUL-1:0][P_W-1:0] prod_i,
  input  logic                        add_lo_i,
  input  logic                        add_hi_i,
  input  logic [RES_W-1:0]            chain_i,
  output logic [RES_W-1:0]            total_o
);

  localparam int PAIR_W = P_W + 1;

  logic signed [PAIR_W-1:0] pair_lo;
  logic signed [PAIR_W-1:0] pair_hi;

  assign pair_lo = add_lo_i ? PAIR_W'($signed(prod_i[0])) + PAIR_W'($signed(prod_i[1]))
                            : PAIR_W'($signed(prod_i[0])) - PAIR_W'($signed(prod_i[1]));

  if (NUM_MUL == 4) begin : g_hi_pair
    assign pair_hi = add_hi_i ? PAIR_W'($signed(prod_i[2])) + PAIR_W'($signed(prod_i[3]))
                              : PAIR_W'($signed(prod_i[2])) - PAIR_W'($signed(prod_i[3]));
  end else begin : g_no_hi
    assign pair_hi = '0;
  end

  assign total_o = RES_W'(pair_lo) + RES_W'(pair_hi) + chain_i;

endmodule

// File: rtl/sop4_acc.sv
module sop4_acc #(
  parameter int RES_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [RES_W-1:0] total_i,
  output logic [RES_W-1:0] acc_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_o <= '0;
    else if (clr_i)  acc_o <= '0;
    else if (en_i)   acc_o <= load_i ? total_i : acc_o + total_i;
  end

endmodule

// File: rtl/sop4_unit.sv
module sop4_unit
  import sop4_pkg::*;
#(
  parameter int NUM_MUL = 4,   // 2 or 4
  parameter int A_W     = 8,
  parameter int B_W     = 8,
  parameter int RES_W   = 48
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   clr_i,
  input  logic                   sgn_a_i,
  input  logic                   sgn_b_i,
  input  logic                   add_lo_i,
  input  logic                   add_hi_i,
  input  logic                   load_i,
  input  logic                   scan_sel_i,
  input  logic [NUM_MUL*A_W-1:0] a_i,
  input  logic [NUM_MUL*B_W-1:0] b_i,
  input  logic [A_W-1:0]         scan_in_i,
  input  logic [RES_W-1:0]       chain_i,
  output logic [RES_W-1:0]       result_o,
  output logic [A_W-1:0]         scan_out_o
);

  localparam int P_W = A_W + B_W + 2;

  sop_ctrl_t                   ctrl_d;
  sop_ctrl_t                   ctrl_s1;
  logic [NUM_MUL-1:0][A_W-1:0] a_stage;
  logic [NUM_MUL-1:0][B_W-1:0] b_stage;
  logic [RES_W-1:0]            chain_s1;
  logic [NUM_MUL-1:0][P_W-1:0] prod;
  logic                        add_lo_s2;
  logic                        add_hi_s2;
  logic                        ld_q;
  logic [RES_W-1:0]            chain_s2;
  logic [RES_W-1:0]            total;

  assign ctrl_d = '{sgn_a: sgn_a_i, sgn_b: sgn_b_i, add_lo: add_lo_i,
                    add_hi: add_hi_i, load: load_i};

  sop4_in_stage #(
    .NUM_MUL (NUM_MUL),
    .A_W     (A_W),
    .B_W     (B_W),
    .RES_W   (RES_W)
  ) u_in (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .clr_i      (clr_i),
    .a_i        (a_i),
    .b_i        (b_i),
    .scan_in_i  (scan_in_i),
    .scan_sel_i (scan_sel_i),
    .ctrl_i     (ctrl_d),
    .chain_i    (chain_i),
    .a_q_o      (a_stage),
    .b_q_o      (b_stage),
    .ctrl_q_o   (ctrl_s1),
    .chain_q_o  (chain_s1)
  );

  for (genvar k = 0; k < NUM_MUL; k++) begin : g_mul
    sop4_mul #(
      .A_W (A_W),
      .B_W (B_W),
      .P_W (P_W)
    ) u_mul (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_i),
      .clr_i   (clr_i),
      .a_i     (a_stage[k]),
      .b_i     (b_stage[k]),
      .sgn_a_i (ctrl_s1.sgn_a),
      .sgn_b_i (ctrl_s1.sgn_b),
      .prod_o  (prod[k])
    );
  end

  // controls and cascade travel alongside the products
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      add_lo_s2 <= 1'b0;
      add_hi_s2 <= 1'b0;
      ld_q      <= 1'b0;
      chain_s2  <= '0;
    end else if (clr_i) begin
      add_lo_s2 <= 1'b0;
      add_hi_s2 <= 1'b0;
      ld_q      <= 1'b0;
      chain_s2  <= '0;
    end else if (en_i) begin
      add_lo_s2 <= ctrl_s1.add_lo;
      add_hi_s2 <= ctrl_s1.add_hi;
      ld_q      <= ctrl_s1.load;
      chain_s2  <= chain_s1;
    end
  end

  sop4_adder #(
    .NUM_MUL (NUM_MUL),
    .P_W     (P_W),
    .RES_W   (RES_W)
  ) u_add (
    .prod_i   (prod),
    .add_lo_i (add_lo_s2),
    .add_hi_i (add_hi_s2),
    .chain_i  (chain_s2),
    .total_o  (total)
  );

  sop4_acc #(
    .RES_W (RES_W)
  ) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .clr_i   (clr_i),
    .load_i  (ld_q),
    .total_i (total),
    .acc_o   (result_o)
  );

  assign scan_out_o = a_stage[NUM_MUL-1];

endmodule

// File: rtl/sop4_unit_chk.sv
module sop4_unit_chk #(
  parameter int NUM_MUL = 4,
  parameter int A_W     = 8,
  parameter int RES_W   = 48
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        en_i,
  input logic                        clr_i,
  input logic                        scan_sel_i,
  input logic [RES_W-1:0]            result_o,
  input logic [A_W-1:0]              scan_out_o,
  input logic [NUM_MUL-1:0][A_W-1:0] a_stage,
  input logic                        ld_q,
  input logic [RES_W-1:0]            total
);

  p_clear_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (result_o == '0) && (scan_out_o == '0));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(result_o) && $stable(scan_out_o));

  p_scan_shift_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && scan_sel_i) |=> scan_out_o == $past(a_stage[NUM_MUL-2]));

  p_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && ld_q) |=> result_o == $past(total));

  p_acc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && !ld_q) |=> result_o == $past(result_o + total));

endmodule

bind sop4_unit sop4_unit_chk #(
  .NUM_MUL (NUM_MUL),
  .A_W     (A_W),
  .RES_W   (RES_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .clr_i      (clr_i),
  .scan_sel_i (scan_sel_i),
  .result_o   (result_o),
  .scan_out_o (scan_out_o),
  .a_stage    (a_stage),
  .ld_q       (ld_q),
  .total      (total)
);

// File: tb/sop4_unit_bench.sv
module sop4_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b1;
  logic        clr_i = 1'b0;
  logic        sgn_a_i = 1'b0;
  logic        sgn_b_i = 1'b0;
  logic        add_lo_i = 1'b1;
  logic        add_hi_i = 1'b1;
  logic        load_i = 1'b0;
  logic        scan_sel_i = 1'b0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [7:0]  scan_in_i = '0;
  logic [47:0] chain_i = '0;
  logic [47:0] result_o;
  logic [7:0]  scan_out_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [3:0][7:0] ma = '0;
  longint          macc = 0;

  int          rq_due[$];
  logic [47:0] rq_exp[$];
  string       rq_tag[$];
  int          sq_due[$];
  logic [7:0]  sq_exp[$];

  sop4_unit u_sop4_unit (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .clr_i      (clr_i),
    .sgn_a_i    (sgn_a_i),
    .sgn_b_i    (sgn_b_i),
    .add_lo_i   (add_lo_i),
    .add_hi_i   (add_hi_i),
    .load_i     (load_i),
    .scan_sel_i (scan_sel_i),
    .a_i        (a_i),
    .b_i        (b_i),
    .scan_in_i  (scan_in_i),
    .chain_i    (chain_i),
    .result_o   (result_o),
    .scan_out_o (scan_out_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic longint ext8(input logic [7:0] v, input logic sgn);
    return sgn ? longint'($signed(v)) : longint'({56'd0, v});
  endfunction

  // driver: called at a falling edge, models the vector and applies it
  task automatic drive(input logic [3:0][7:0] av, input logic [3:0][7:0] bv,
                       input logic sa, input logic sb, input logic al, input logic ah,
                       input logic ld, input logic ss, input logic [7:0] si,
                       input longint ch, input string tag);
    logic [3:0][7:0] na;
    longint p[4];
    longint lo, hi, s;
    na[0] = ss ? si : av[0];
    for (int k = 1; k < 4; k++) na[k] = ss ? ma[k-1] : av[k];
    for (int k = 0; k < 4; k++) p[k] = ext8(na[k], sa) * ext8(bv[k], sb);
    lo = al ? p[0] + p[1] : p[0] - p[1];
    hi = ah ? p[2] + p[3] : p[2] - p[3];
    s  = lo + hi + ch;
    macc = ld ? s : macc + s;
    ma = na;
    rq_due.push_back(cyc + 3);
    rq_exp.push_back(macc[47:0]);
    rq_tag.push_back(tag);
    sq_due.push_back(cyc + 1);
    sq_exp.push_back(na[3]);
    a_i = av; b_i = bv;
    sgn_a_i = sa; sgn_b_i = sb; add_lo_i = al; add_hi_i = ah;
    load_i = ld; scan_sel_i = ss; scan_in_i = si; chain_i = ch[47:0];
    @(negedge clk);
  endtask

  task automatic idle();
    drive('0, '0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd0, 0, "R8");
  endtask

  // monitor: compares results as they emerge
  always @(negedge clk) begin
    #1;
    if (rq_due.size() > 0 && rq_due[0] <= cyc) begin
      chk(result_o == rq_exp[0], rq_tag[0], result_o, rq_exp[0]);
      void'(rq_due.pop_front()); void'(rq_exp.pop_front()); void'(rq_tag.pop_front());
    end
    if (sq_due.size() > 0 && sq_due[0] <= cyc) begin
      chk(scan_out_o == sq_exp[0], "R7 scan_out", 48'(scan_out_o), 48'(sq_exp[0]));
      void'(sq_due.pop_front()); void'(sq_exp.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [47:0] r0;
    logic [7:0]  s0;
    repeat (3) @(negedge clk);
    chk(result_o == '0, "R11 reset result", result_o, '0);
    chk(scan_out_o == '0, "R11 reset scan", 48'(scan_out_o), '0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R8 latency and plain unsigned sum
    drive({8'd9, 8'd7, 8'd5, 8'd3}, {8'd8, 8'd6, 8'd4, 8'd2}, 0, 0, 1, 1, 1, 0, 0, 0, "R8");
    // R1 signed vs unsigned A
    drive({8'd0, 8'd0, 8'd0, 8'hFF}, {8'd0, 8'd0, 8'd0, 8'd10}, 1, 0, 1, 1, 1, 0, 0, 0, "R1");
    drive({8'd0, 8'd0, 8'd0, 8'hFF}, {8'd0, 8'd0, 8'd0, 8'd10}, 0, 0, 1, 1, 1, 0, 0, 0, "R1");
    // R2 signed vs unsigned B
    drive({8'd0, 8'd0, 8'd0, 8'd3}, {8'd0, 8'd0, 8'd0, 8'h80}, 0, 1, 1, 1, 1, 0, 0, 0, "R2");
    drive({8'd0, 8'd0, 8'd0, 8'd3}, {8'd0, 8'd0, 8'd0, 8'h80}, 0, 0, 1, 1, 1, 0, 0, 0, "R2");
    drive({4{8'h80}}, {4{8'h80}}, 1, 1, 1, 1, 1, 0, 0, 0, "R1");
    // R3 / R4 subtraction per pair
    drive({8'd0, 8'd0, 8'd5, 8'd3}, {8'd0, 8'd0, 8'd7, 8'd2}, 0, 0, 0, 1, 1, 0, 0, 0, "R3");
    drive({8'd4, 8'd6, 8'd0, 8'd0}, {8'd9, 8'd3, 8'd0, 8'd0}, 0, 0, 1, 0, 1, 0, 0, 0, "R4");
    drive({4{8'hFF}}, {4{8'hFF}}, 1, 0, 0, 0, 1, 0, 0, 0, "R4");
    drive({4{8'hFF}}, {4{8'hFF}}, 0, 0, 1, 1, 1, 0, 0, 0, "R8");
    // R6 cascade input
    drive({8'd0, 8'd0, 8'd0, 8'd2}, {8'd0, 8'd0, 8'd0, 8'd2}, 0, 0, 1, 1, 1, 0, 0, -1000, "R6");
    drive({8'd0, 8'd0, 8'd0, 8'd2}, {8'd0, 8'd0, 8'd0, 8'd2}, 0, 0, 1, 1, 1, 0, 0, 64'd1 << 40, "R6");
    // R5 load then accumulate
    drive({4{8'd1}}, {4{8'd5}}, 0, 0, 1, 1, 1, 0, 0, 0, "R5");
    for (int i = 0; i < 3; i++)
      drive({4{8'd1}}, {4{8'd5}}, 0, 0, 1, 1, 0, 0, 0, 0, "R5");
    drive({8'd0, 8'd0, 8'd0, 8'd1}, {8'd0, 8'd0, 8'd0, 8'd1}, 0, 0, 1, 1, 1, 0, 0, 0, "R5");
    drive({8'd0, 8'd0, 8'd2, 8'd0}, {8'd0, 8'd0, 8'd9, 8'd0}, 0, 0, 0, 1, 0, 0, 0, 0, "R5");
    // R7 scan chain, parallel inputs ignored
    for (int i = 1; i <= 5; i++)
      drive({4{8'hAA}}, {4{8'd1}}, 0, 0, 1, 1, 1, 1, 8'(11 * i), 0, "R7");
    drive({8'd1, 8'd2, 8'd3, 8'd4}, {4{8'd1}}, 0, 0, 1, 1, 1, 0, 8'hEE, 0, "R7");
    idle();
    repeat (4) @(negedge clk);

    // R9 enable low holds everything
    r0 = result_o; s0 = scan_out_o;
    en_i = 1'b0; a_i = 32'h5555_5555; b_i = 32'h3333_3333; load_i = 1'b1;
    scan_sel_i = 1'b1; scan_in_i = 8'h77; chain_i = 48'd123;
    repeat (4) begin
      @(negedge clk); #1;
      chk(result_o == r0, "R9 hold result", result_o, r0);
      chk(scan_out_o == s0, "R9 hold scan", 48'(scan_out_o), 48'(s0));
    end
    a_i = '0; b_i = '0; load_i = 1'b0; scan_sel_i = 1'b0; scan_in_i = '0;
    chain_i = '0; en_i = 1'b1;
    @(negedge clk);
    drive({8'd0, 8'd0, 8'd0, 8'd7}, {8'd0, 8'd0, 8'd0, 8'd6}, 0, 0, 1, 1, 1, 0, 0, 0, "R9");
    drive({8'd9, 8'd0, 8'd0, 8'd0}, {8'd2, 8'd0, 8'd0, 8'd0}, 0, 0, 1, 1, 0, 0, 0, 0, "R9");
    idle();
    repeat (4) @(negedge clk);

    // R10 clear with enable low
    en_i = 1'b0; clr_i = 1'b1;
    @(negedge clk); #1;
    chk(result_o == '0, "R10 clear result", result_o, '0);
    chk(scan_out_o == '0, "R10 clear scan", 48'(scan_out_o), '0);
    clr_i = 1'b0; en_i = 1'b1;
    macc = 0; ma = '0;
    @(negedge clk);
    drive({8'd0, 8'd0, 8'd0, 8'd3}, {8'd0, 8'd0, 8'd0, 8'd3}, 0, 0, 1, 1, 0, 0, 0, 0, "R10");
    idle();
    repeat (4) @(negedge clk);

    // R11 asynchronous reset between edges
    #2 rst_ni = 1'b0;
    #1;
    chk(result_o == '0, "R11 async result", result_o, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule